// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

This block sits on the host side of an asynchronous pseudo-SRAM that has page mode enabled. It reads bursts of words. A request carries a start address, a word count minus one and a byte-lane mask. The sequencer drives the memory's active-low chip select, output enable, write enable, byte enables and address. It returns each word on `rd_data` together with a one-cycle `rd_valid` strobe.

All memory timing is given in nanoseconds as parameters. Each value is converted to clock cycles by rounding up. The first word of a burst is read with a full random-access cycle. Later words inside the same 16-word page are read with the short in-page cycle, while chip select stays low. When the next address lies in a new page, chip select stays low and that access gets the full random-access time. The memory limits how long chip select may stay low. Before every access the sequencer checks whether that access would push the low period past the limit. If it would, chip select is raised for the minimum high time and the burst resumes with a random cycle.

Top module: `psram_page_reader`

## Requirements
- R1: While `rst` is high and in the first cycle after it: `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_be_n` is all ones, `rd_valid` is 0 and `req_ready` is 1.
- R2: Whenever `mem_cs_n` is 0, `mem_oe_n` is 0 and `mem_be_n[i]` equals the inverse of `req_be[i]` from the accepted request. Bit 1 is the upper lane, data bits 15..8, and bit 0 is the lower lane, bits 7..0. `mem_we_n` is always 1. While `mem_cs_n` is 1, `mem_oe_n` and every `mem_be_n` bit are 1.
- R3: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge onward. It returns to 1 exactly CPH_CYC cycles after the cycle in which the final word's `rd_valid` is high.
- R4: A request returns exactly `req_len`+1 words. They come from `req_addr` upward, wrapping modulo 2^ADDR_W. Each word is shown for one cycle with `rd_valid` high. Byte lanes that are not enabled read as zero.
- R5: The first word's `rd_valid` is high RC_CYC cycles after the acceptance edge.
- R6: If the next address has the same bits above bit 3 and no break is needed, the next word follows PC_CYC cycles after the previous one, and chip select stays low. The address may not change sooner than PC_CYC cycles after the previous change.
- R7: If the next address is in a new 16-word page, the next word follows RC_CYC cycles after the previous one.
- R8: `mem_cs_n` is never low for more than CSL_CYC cycles in a row. If the next access would exceed that, chip select goes high for CPH_CYC cycles and a random access follows. The word interval is then CPH_CYC+RC_CYC. Every fall of chip select comes after at least CPH_CYC cycles high.
- R9: `req_valid` has no effect while `req_ready` is 0. The running burst keeps its address sequence and word count, and no extra words appear.
- R10: RC_CYC, PC_CYC, CPH_CYC and CSL_CYC are ceil(T_RC_NS/CLK_NS), ceil(T_PC_NS/CLK_NS), ceil(T_CPH_NS/CLK_NS) and ceil(T_CSL_NS/CLK_NS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | ADDR_W | First word address |
| req_len | input | LEN_W | Number of words minus one |
| req_be | input | DATA_W/8 | Byte-lane mask, bit 1 upper, bit 0 lower |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, held high |
| mem_be_n | output | DATA_W/8 | Memory byte enables, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_dq | input | DATA_W | Memory read data |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | DATA_W | Returned word, disabled lanes zero |

## Verification
The properties assume that `mem_dq` is valid by the time the access count expires. They also assume PC_CYC is at least 2, so that consecutive strobes cannot touch, and that CSL_CYC exceeds RC_CYC. The bench supplies read data from a device model. That model returns the inverted word whenever an access is sampled before its in-page or random access time has passed. It also records early address changes, over-long chip-select-low periods and short high periods. Requests mix random addresses, lengths and masks (including an empty mask) with directed bursts. The directed bursts cross a page, wrap at the top of the address space, are a single word, and run long enough to force a low-time break. One of them asserts `req_valid` during a busy burst.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [1:0] {
    PRD_IDLE,
    PRD_ACCESS,
    PRD_GAP
  } prd_state_e;

  // round a nanosecond figure up to whole clock periods
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/prd_timer.sv
module prd_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/prd_csl_guard.sv
module prd_csl_guard #(
  parameter int LOW_W   = 12,
  parameter int DUR_W   = 5,
  parameter int CSL_CYC = 2500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_low,
  input  logic [DUR_W-1:0] next_dur,
  output logic             fits
);

  logic [LOW_W-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst)                low_q <= '0;
    else if (!cs_low)       low_q <= '0;
    else if (low_q != '1)   low_q <= low_q + 1'b1;
  end

  // elapsed low time at this edge is low_q+1; the next access adds next_dur
  always_comb begin
    fits = (int'(low_q) + 1 + int'(next_dur)) <= CSL_CYC;
  end

endmodule

// File: rtl/prd_addr_step.sv
module prd_addr_step #(
  parameter int ADDR_W    = 20,
  parameter int PAGE_BITS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic              crosses
);

  assign next_addr = addr + 1'b1;
  assign crosses   = &addr[PAGE_BITS-1:0];

endmodule

// File: rtl/prd_lane_mask.sv
module prd_lane_mask #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   din,
  input  logic [DATA_W/8-1:0] lane_en,
  output logic [DATA_W-1:0]   dout
);

  for (genvar g = 0; g < DATA_W / 8; g++) begin : g_lane
    assign dout[g*8 +: 8] = lane_en[g] ? din[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader #(
  parameter int CLK_NS    = 4,
  parameter int T_RC_NS   = 70,
  parameter int T_PC_NS   = 20,
  parameter int T_CPH_NS  = 10,
  parameter int T_CSL_NS  = 10000,
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 10,
  parameter int PAGE_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]   mem_dq,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);

  import prd_pkg::*;

  localparam int BE_W    = DATA_W / 8;
  localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int PC_CYC  = ns_to_cyc(T_PC_NS, CLK_NS);
  localparam int CPH_CYC = ns_to_cyc(T_CPH_NS, CLK_NS);
  localparam int CSL_CYC = ns_to_cyc(T_CSL_NS, CLK_NS);
  localparam int TMR_W   = $clog2(RC_CYC + PC_CYC + CPH_CYC + 1);
  localparam int LOW_W   = $clog2(CSL_CYC + RC_CYC + 2);

  prd_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [BE_W-1:0]   be_q;
  logic              cs_n_q, oe_n_q, resume_q, ready_q, valid_q;
  logic [BE_W-1:0]   be_n_q;
  logic [DATA_W-1:0] data_q;

  logic              tmr_zero, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] next_addr;
  logic              crosses, fits;
  logic [TMR_W-1:0]  next_dur;
  logic [DATA_W-1:0] masked;
  logic              start, capture, go_on, gap_done;

  prd_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  prd_addr_step #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_step (
    .addr(addr_q), .next_addr(next_addr), .crosses(crosses)
  );

  prd_csl_guard #(.LOW_W(LOW_W), .DUR_W(TMR_W), .CSL_CYC(CSL_CYC)) u_guard (
    .clk(clk), .rst(rst), .cs_low(!cs_n_q), .next_dur(next_dur), .fits(fits)
  );

  prd_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .din(mem_dq), .lane_en(be_q), .dout(masked)
  );

  always_comb begin
    next_dur = crosses ? TMR_W'(RC_CYC) : TMR_W'(PC_CYC);
    start    = (state_q == PRD_IDLE) && req_valid;
    capture  = (state_q == PRD_ACCESS) && tmr_zero;
    gap_done = (state_q == PRD_GAP) && tmr_zero;
    go_on    = capture && (left_q != '0) && fits;
    tmr_load = start || capture || gap_done;
    if (start || gap_done) tmr_val = TMR_W'(RC_CYC - 1);
    else if (go_on)        tmr_val = next_dur - 1'b1;
    else                   tmr_val = TMR_W'(CPH_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PRD_IDLE;
      addr_q   <= '0;
      left_q   <= '0;
      be_q     <= '0;
      cs_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      be_n_q   <= '1;
      resume_q <= 1'b0;
      ready_q  <= 1'b1;
      valid_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        PRD_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            left_q  <= req_len;
            be_q    <= req_be;
            cs_n_q  <= 1'b0;
            oe_n_q  <= 1'b0;
            be_n_q  <= ~req_be;
            ready_q <= 1'b0;
            state_q <= PRD_ACCESS;
          end
        end
        PRD_ACCESS: begin
          if (tmr_zero) begin
            valid_q <= 1'b1;
            data_q  <= masked;
            if (left_q == '0) begin
              cs_n_q   <= 1'b1;
              oe_n_q   <= 1'b1;
              be_n_q   <= '1;
              resume_q <= 1'b0;
              state_q  <= PRD_GAP;
            end else begin
              addr_q <= next_addr;
              left_q <= left_q - 1'b1;
              if (!fits) begin
                cs_n_q   <= 1'b1;
                oe_n_q   <= 1'b1;
                be_n_q   <= '1;
                resume_q <= 1'b1;
                state_q  <= PRD_GAP;
              end
            end
          end
        end
        PRD_GAP: begin
          if (tmr_zero) begin
            if (resume_q) begin
              cs_n_q  <= 1'b0;
              oe_n_q  <= 1'b0;
              be_n_q  <= ~be_q;
              state_q <= PRD_ACCESS;
            end else begin
              ready_q <= 1'b1;
              state_q <= PRD_IDLE;
            end
          end
        end
        default: state_q <= PRD_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign mem_cs_n  = cs_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_we_n  = 1'b1;
  assign mem_be_n  = be_n_q;
  assign mem_addr  = addr_q;
  assign rd_valid  = valid_q;
  assign rd_data   = data_q;

endmodule

// File: rtl/prd_chk.sv
module prd_chk #(
  parameter int ADDR_W    = 20,
  parameter int BE_W      = 2,
  parameter int PAGE_BITS = 4,
  parameter int RC_CYC    = 18,
  parameter int PC_CYC    = 5,
  parameter int CPH_CYC   = 3,
  parameter int CSL_CYC   = 2500
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [BE_W-1:0]   mem_be_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rd_valid,
  input logic              req_ready
);

  int                unsigned hi_cnt, low_cnt, hold_cnt, need_cnt;
  logic              last_cs_n;
  logic [ADDR_W-1:0] last_addr;
  logic              addr_moved;

  assign addr_moved = !mem_cs_n && !last_cs_n && (mem_addr != last_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= CPH_CYC;
      low_cnt   <= 0;
      hold_cnt  <= 0;
      need_cnt  <= RC_CYC;
      last_cs_n <= 1'b1;
      last_addr <= '0;
    end else begin
      last_cs_n <= mem_cs_n;
      last_addr <= mem_addr;
      if (mem_cs_n) begin
        low_cnt  <= 0;
        hold_cnt <= 0;
        if (hi_cnt < CPH_CYC) hi_cnt <= hi_cnt + 1;
      end else begin
        hi_cnt  <= 0;
        low_cnt <= low_cnt + 1;
        if (last_cs_n) begin
          hold_cnt <= 1;
          need_cnt <= RC_CYC;
        end else if (addr_moved) begin
          hold_cnt <= 1;
          need_cnt <= (mem_addr[ADDR_W-1:PAGE_BITS] != last_addr[ADDR_W-1:PAGE_BITS])
                      ? RC_CYC : PC_CYC;
        end else begin
          hold_cnt <= hold_cnt + 1;
        end
      end
    end
  end

  // R2
  read_sig_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> (!mem_oe_n && mem_we_n));

  // R2
  lanes_off_chk: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> (mem_oe_n && (&mem_be_n)));

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_cs_n);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R6 R7
  page_pace_chk: assert property (@(posedge clk) disable iff (rst)
    addr_moved |-> (hold_cnt >= need_cnt));

  // R7
  access_end_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n && !last_cs_n) |-> (hold_cnt >= need_cnt));

  // R8
  csl_limit_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> (low_cnt < CSL_CYC));

  // R8
  cph_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> (hi_cnt >= CPH_CYC));

endmodule

bind psram_page_reader prd_chk #(
  .ADDR_W(ADDR_W), .BE_W(BE_W), .PAGE_BITS(PAGE_BITS),
  .RC_CYC(RC_CYC), .PC_CYC(PC_CYC), .CPH_CYC(CPH_CYC), .CSL_CYC(CSL_CYC)
) u_chk (
  .clk(clk), .rst(rst), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
  .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/psram_page_reader_tb.sv
`timescale 1ns/1ps
module psram_page_reader_tb;

  localparam int CLK_NS = 4;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 10;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // R10 expected cycle counts from nanosecond figures
  localparam int RC  = cdiv(70, CLK_NS);
  localparam int PC  = cdiv(20, CLK_NS);
  localparam int CPH = cdiv(10, CLK_NS);
  localparam int CSL = cdiv(10000, CLK_NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [1:0]        req_be = '0;
  logic mem_cs_n, mem_oe_n, mem_we_n;
  logic [1:0]        mem_be_n;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_dq;
  logic rd_valid;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_NS/2.0) clk = ~clk;

  psram_page_reader u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [15:0] word_of(input logic [ADDR_W-1:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], a[19:16], a[19:16]} ^ 16'hC35A;
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  // timing-checking device model
  logic              m_last_cs_n;
  logic [ADDR_W-1:0] m_last_addr;
  int m_held, m_need, m_low, m_high;
  int m_early = 0;
  int m_long = 0;
  int m_short_hi = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_last_cs_n <= 1'b1;
      m_last_addr <= '0;
      m_held <= 0; m_need <= RC; m_low <= 0; m_high <= CPH;
    end else begin
      m_last_cs_n <= mem_cs_n;
      m_last_addr <= mem_addr;
      if (mem_cs_n) begin
        m_held <= 0; m_low <= 0;
        if (m_high < CPH) m_high <= m_high + 1;
      end else begin
        m_high <= 0;
        m_low  <= m_low + 1;
        if (m_low + 1 > CSL) m_long <= m_long + 1;
        if (m_last_cs_n) begin
          if (m_high < CPH) m_short_hi <= m_short_hi + 1;
          m_held <= 1; m_need <= RC;
        end else if (mem_addr != m_last_addr) begin
          if (m_held < m_need) m_early <= m_early + 1;
          m_held <= 1;
          m_need <= (mem_addr[19:4] != m_last_addr[19:4]) ? RC : PC;
        end else begin
          m_held <= m_held + 1;
        end
      end
    end
  end

  assign mem_dq = (!mem_cs_n && !mem_oe_n && !m_last_cs_n && mem_addr == m_last_addr &&
                   m_held >= 1 && m_held + 1 >= m_need) ? word_of(mem_addr)
                                                        : ~word_of(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic burst(input logic [ADDR_W-1:0] a, input int len, input logic [1:0] be,
                       input bit poke);
    int k = 0;
    int last_k = 0;
    int words = 0;
    int low = 0;
    int j = 0;
    int exp_gap;
    bit sig_ok = 1'b1;
    bit extra = 1'b0;
    bit prev_cross = 1'b0;
    logic [ADDR_W-1:0] cur = a;
    while (!req_ready && j < 100) begin @(negedge clk); j++; end
    req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len); req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R3 ready drop", req_ready, 0);
    while (words < len + 1 && k < 20000) begin
      @(negedge clk);
      k++;
      if (poke && k == 7) begin
        req_valid = 1'b1; req_addr = a ^ 20'h5555; req_len = '1;
      end
      if (poke && k == 8) req_valid = 1'b0;
      if (!mem_cs_n) sig_ok &= (!mem_oe_n && mem_we_n && mem_be_n == ~be);
      else           sig_ok &= (mem_oe_n && mem_be_n == 2'b11 && mem_we_n);
      if (rd_valid) begin
        if (words == 0) begin
          chk(k == RC, "R5 R10 first latency", k, RC);
          low = RC;
        end else begin
          int d = prev_cross ? RC : PC;
          if (low + d > CSL) begin
            exp_gap = CPH + RC; low = RC;
            chk(k - last_k == exp_gap, "R8 break interval", k - last_k, exp_gap);
          end else begin
            exp_gap = d; low += d;
            chk(k - last_k == exp_gap, prev_cross ? "R7 page cross interval"
                                                  : "R6 in-page interval",
                k - last_k, exp_gap);
          end
        end
        chk(rd_data == lanes(word_of(cur), be), "R4 data", rd_data, lanes(word_of(cur), be));
        prev_cross = (cur[3:0] == 4'hF);
        cur = cur + 1'b1;
        words++;
        last_k = k;
      end
    end
    chk(words == len + 1, poke ? "R9 word count" : "R4 word count", words, len + 1);
    chk(sig_ok, "R2 strobes", sig_ok, 1);
    j = 0;
    while (!req_ready && j < 100) begin
      @(negedge clk); j++;
      if (rd_valid) extra = 1'b1;
    end
    chk(j == CPH, "R3 ready return", j, CPH);
    chk(!extra, poke ? "R9 no extra word" : "R4 no extra word", extra, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !rd_valid && req_ready,
        "R1 reset outputs", {mem_cs_n, mem_oe_n, mem_we_n, rd_valid, req_ready}, 5'b11101);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && req_ready && !rd_valid, "R1 after reset", {mem_cs_n, req_ready}, 2'b11);

    burst(20'h0000E, 5, 2'b11, 1'b0);   // page crossing
    burst(20'hFFFFE, 3, 2'b10, 1'b0);   // wrap at top
    burst(20'h00100, 0, 2'b01, 1'b0);   // single word
    burst(20'h00230, 20, 2'b00, 1'b1);  // no lanes, busy poke
    burst(20'h00200, 699, 2'b11, 1'b0); // forces low-time break
    for (int i = 0; i < 25; i++) begin
      r = $urandom;
      if (r[31:30] == 2'b00) r[3:0] = 4'hD;
      burst(r[19:0], int'($urandom % 40), 2'($urandom % 4), r[29]);
    end

    chk(m_early == 0, "R6 model early address change", m_early, 0);
    chk(m_long == 0, "R8 model cs low too long", m_long, 0);
    chk(m_short_hi == 0, "R8 model cs high too short", m_short_hi, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule